// File: doc/BRIEF.md
# DMA Channel Request Enable Register Block

This block holds one request enable bit for each of 64 DMA channels. Each bit decides whether that channel's raw hardware request reaches the rest of the DMA engine. Software changes single bits through two byte-wide command ports. It writes a channel number to the set port to enable that channel, or to the clear port to disable it. Another channel or a bus master never has to read, modify and write back a mask. One bit of the command field selects a global action instead: enable all channels, or disable all channels at once.

The 64-bit vector can also be read and written directly as two 32-bit words. A second 64-bit vector holds per-channel error interrupt enables. It masks the channel error flags into a single interrupt request. The bus side is a simple synchronous register port with a one-cycle read latency.

Top module: `dma_req_enable`

## Requirements
- R1: After reset, both enable words, both error-enable words, every gated request output and the interrupt output read as zero.
- R2: A write to the set port (offset 0x18) with data bit 6 clear sets only the enable bit of the channel given in data bits 5:0. The other 63 bits keep their values. The change is visible at the clock edge that samples the write.
- R3: A write to the set port with data bit 6 set (values 64 to 127 in bits 6:0) sets all 64 enable bits.
- R4: A write to the clear port (offset 0x19) with data bit 6 clear clears only the enable bit of the channel given in data bits 5:0.
- R5: A write to the clear port with data bit 6 set clears all 64 enable bits, so that no gated request output can be high.
- R6: Data bit 7 of a command write is reserved and has no effect on the result.
- R7: A read of either command port returns zero in every bit.
- R8: The word at offset 0x08 holds enable bits 63:32, and the word at offset 0x0C holds bits 31:0. Both can be written directly. A read returns the value on rd_data in the cycle after rd_en is sampled.
- R9: Each bit of req_gated equals the matching bit of req_in ANDed with that channel's enable bit.
- R10: The error enable words sit at 0x10 (bits 63:32) and 0x14 (bits 31:0). err_irq is high exactly when some channel has both its error flag and its error enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data; command ports use bits 7:0 |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid one cycle after rd_en |
| req_in | input | 64 | Raw per-channel DMA requests |
| req_gated | output | 64 | Requests masked by the enable vector |
| err_in | input | 64 | Per-channel error flags |
| err_irq | output | 1 | Combined error interrupt request |

## Verification
The hardest case to reach is a command whose reserved top bit is set. Such a command must act exactly like the same command without that bit, both in the single-channel range and in the global range. The stimulus first builds a known mixed vector with single-channel set commands. It then issues a set command with bit 7 set and reads both words back. Any decode that treats bit 7 as part of the channel field, or as the global selector, would then show up as an extra or missing enable bit. The global clear is also issued only after a global set and a single clear. This shows that it removes a vector that is full except for one bit.

// File: rtl/dma_req_enable_pkg.sv
// Package: shared sizes, register offsets and read-select type for the
// DMA request enable block. Assumes the channel count is twice the word width.
package dma_req_enable_pkg;
    localparam int CH_N    = 64;
    localparam int WORD_W  = 32;
    localparam int IDX_W   = $clog2(CH_N);
    localparam int CMD_W   = IDX_W + 1;
    localparam int ADDR_W  = 8;

    localparam logic [ADDR_W-1:0] OFS_EN_HI  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_EN_LO  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_EE_HI  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_EE_LO  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_SET    = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_CLR    = 8'h19;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EN_HI,
        SEL_EN_LO,
        SEL_EE_HI,
        SEL_EE_LO
    } rd_sel_e;
endpackage

// File: rtl/dma_req_cmd_decode.sv
// Module: turns a command field into a per-channel select mask.
// Assumes the field MSB is the global selector and the lower bits are the
// channel index. The reserved command bit is never presented here.
module dma_req_cmd_decode #(
    parameter int CH_N  = 64,
    parameter int IDX_W = $clog2(CH_N),
    parameter int CMD_W = IDX_W + 1
) (
    input  logic             valid,
    input  logic [CMD_W-1:0] cmd,
    output logic [CH_N-1:0]  mask
);
    // One select per channel: global selector or index match.
    for (genvar i = 0; i < CH_N; i++) begin : g_sel
        assign mask[i] = valid & (cmd[CMD_W-1] | (cmd[IDX_W-1:0] == IDX_W'(i)));
    end
endmodule

// File: rtl/dma_req_vec_reg.sv
// Module: a vector register held as NWORD words, with direct word writes and
// per-bit set/clear masks. Clear takes priority over set, and both over a
// direct write. Synchronous active-low reset to zero.
module dma_req_vec_reg #(
    parameter int CH_N   = 64,
    parameter int WORD_W = 32,
    localparam int NWORD = CH_N / WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NWORD-1:0]  word_we,
    input  logic [WORD_W-1:0] wdata,
    input  logic [CH_N-1:0]   set_mask,
    input  logic [CH_N-1:0]   clr_mask,
    output logic [CH_N-1:0]   vec_q
);
    logic [CH_N-1:0] vec_wr;

    // Apply direct word writes to the current value.
    for (genvar w = 0; w < NWORD; w++) begin : g_word
        assign vec_wr[w*WORD_W +: WORD_W] = word_we[w] ? wdata : vec_q[w*WORD_W +: WORD_W];
    end

    // Register the vector; set then clear so clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n) vec_q <= '0;
        else        vec_q <= (vec_wr | set_mask) & ~clr_mask;
    end
endmodule

// File: rtl/dma_req_gate.sv
// Module: masks raw requests with enables and combines error flags with
// their interrupt enables into one request. Purely combinational.
module dma_req_gate #(
    parameter int CH_N = 64
) (
    input  logic [CH_N-1:0] req_in,
    input  logic [CH_N-1:0] en,
    input  logic [CH_N-1:0] err_in,
    input  logic [CH_N-1:0] err_en,
    output logic [CH_N-1:0] req_gated,
    output logic            err_irq
);
    // Gate requests and reduce masked errors.
    always_comb begin
        req_gated = req_in & en;
        err_irq   = |(err_in & err_en);
    end
endmodule

// File: rtl/dma_req_enable.sv
// Module: top of the DMA request enable block. It decodes bus writes into
// direct word writes and set/clear commands, holds the enable and error
// enable vectors, and returns registered read data one cycle after rd_en.
// Assumes a single bus access per cycle.
module dma_req_enable
    import dma_req_enable_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    input  logic [CH_N-1:0]   req_in,
    output logic [CH_N-1:0]   req_gated,
    input  logic [CH_N-1:0]   err_in,
    output logic              err_irq
);
    localparam int NWORD = CH_N / WORD_W;

    logic [CH_N-1:0]  set_mask, clr_mask, en_q, ee_q;
    logic [NWORD-1:0] en_we, ee_we;
    logic             set_hit, clr_hit;
    rd_sel_e          rd_sel;

    // Decode write strobes (word 1 = high half, word 0 = low half).
    always_comb begin
        set_hit  = wr_en && (addr == OFS_SET);
        clr_hit  = wr_en && (addr == OFS_CLR);
        en_we[1] = wr_en && (addr == OFS_EN_HI);
        en_we[0] = wr_en && (addr == OFS_EN_LO);
        ee_we[1] = wr_en && (addr == OFS_EE_HI);
        ee_we[0] = wr_en && (addr == OFS_EE_LO);
    end

    dma_req_cmd_decode #(.CH_N(CH_N)) u_set_dec (
        .valid(set_hit), .cmd(wr_data[CMD_W-1:0]), .mask(set_mask)
    );
    dma_req_cmd_decode #(.CH_N(CH_N)) u_clr_dec (
        .valid(clr_hit), .cmd(wr_data[CMD_W-1:0]), .mask(clr_mask)
    );

    dma_req_vec_reg #(.CH_N(CH_N), .WORD_W(WORD_W)) u_en_reg (
        .clk(clk), .rst_n(rst_n), .word_we(en_we), .wdata(wr_data),
        .set_mask(set_mask), .clr_mask(clr_mask), .vec_q(en_q)
    );
    dma_req_vec_reg #(.CH_N(CH_N), .WORD_W(WORD_W)) u_ee_reg (
        .clk(clk), .rst_n(rst_n), .word_we(ee_we), .wdata(wr_data),
        .set_mask('0), .clr_mask('0), .vec_q(ee_q)
    );

    dma_req_gate #(.CH_N(CH_N)) u_gate (
        .req_in(req_in), .en(en_q), .err_in(err_in), .err_en(ee_q),
        .req_gated(req_gated), .err_irq(err_irq)
    );

    // Select the word to read; command ports and holes read as zero.
    always_comb begin
        unique case (addr)
            OFS_EN_HI: rd_sel = SEL_EN_HI;
            OFS_EN_LO: rd_sel = SEL_EN_LO;
            OFS_EE_HI: rd_sel = SEL_EE_HI;
            OFS_EE_LO: rd_sel = SEL_EE_LO;
            default:   rd_sel = SEL_NONE;
        endcase
    end

    // Register read data one cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else if (rd_en) begin
            case (rd_sel)
                SEL_EN_HI: rd_data <= en_q[CH_N-1:WORD_W];
                SEL_EN_LO: rd_data <= en_q[WORD_W-1:0];
                SEL_EE_HI: rd_data <= ee_q[CH_N-1:WORD_W];
                SEL_EE_LO: rd_data <= ee_q[WORD_W-1:0];
                default:   rd_data <= '0;
            endcase
        end
    end
endmodule

// File: rtl/dma_req_enable_chk.sv
// Module: assertion checker for dma_req_enable, attached by bind.
// It observes bus writes and reads together with the held enable vector.
module dma_req_enable_chk
    import dma_req_enable_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] rd_data,
    input  logic [CH_N-1:0]   en_vec
);
    AST_SET_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_SET && !cmd[CMD_W-1]) |=> en_vec[$past(cmd[IDX_W-1:0])]); // R2
    AST_SET_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_SET && cmd[CMD_W-1]) |=> (&en_vec)); // R3
    AST_CLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CLR && !cmd[CMD_W-1]) |=> !en_vec[$past(cmd[IDX_W-1:0])]); // R4
    AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CLR && cmd[CMD_W-1]) |=> (en_vec == '0)); // R5
    AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == OFS_SET || addr == OFS_CLR)) |=> (rd_data == '0)); // R7
endmodule

bind dma_req_enable dma_req_enable_chk u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .cmd(wr_data[dma_req_enable_pkg::CMD_W-1:0]), .rd_en(rd_en),
    .rd_data(rd_data), .en_vec(en_q)
);

// File: tb/dma_req_enable_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the read task pushes expected words, and a monitor
// pops them and compares them with rd_data in the cycle after each read.
module dma_req_enable_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [63:0] req_in = '0;
    logic [63:0] req_gated;
    logic [63:0] err_in = '0;
    logic        err_irq;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #2 clk = ~clk;

    dma_req_enable u_dma_req_enable (.*);

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        @(negedge clk); addr = a; rd_en = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); rd_en = 1'b0;
    endtask

    // Monitor: note which cycles carried a read.
    always @(posedge clk) rd_seen <= rd_en;
    // Monitor: compare the read result against the scoreboard.
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0)
            check(tag_q.pop_front(), {32'h0, rd_data}, {32'h0, exp_q.pop_front()});
    end

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        req_in = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 gated after reset", req_gated, 64'h0);
        check("R1 irq after reset", {63'h0, err_irq}, 64'h0);
        rd(8'h08, 32'h0, "R1 en hi");
        rd(8'h0C, 32'h0, "R1 en lo");
        rd(8'h14, 32'h0, "R1 ee lo");
        wr(8'h18, 32'd5);
        rd(8'h0C, 32'h0000_0020, "R2 set ch5");
        check("R9 gated ch5", req_gated, 64'h20);
        wr(8'h18, 32'd40);
        rd(8'h08, 32'h0000_0100, "R2 set ch40");
        rd(8'h0C, 32'h0000_0020, "R2 others kept");
        wr(8'h18, 32'h87);
        rd(8'h0C, 32'h0000_00A0, "R6 reserved bit set cmd");
        rd(8'h08, 32'h0000_0100, "R6 reserved bit no global");
        rd(8'h18, 32'h0, "R7 set port reads 0");
        rd(8'h19, 32'h0, "R7 clear port reads 0");
        wr(8'h19, 32'd5);
        rd(8'h0C, 32'h0000_0080, "R4 clear ch5");
        wr(8'h18, 32'd64);
        rd(8'h08, 32'hFFFF_FFFF, "R3 set all hi");
        rd(8'h0C, 32'hFFFF_FFFF, "R3 set all lo");
        wr(8'h19, 32'h8000_003F);
        rd(8'h08, 32'h7FFF_FFFF, "R4 clear ch63");
        wr(8'h19, 32'd127);
        rd(8'h08, 32'h0, "R5 clear all hi");
        rd(8'h0C, 32'h0, "R5 clear all lo");
        check("R5 no request passes", req_gated, 64'h0);
        wr(8'h08, 32'hDEAD_BEEF);
        wr(8'h0C, 32'h1234_5678);
        rd(8'h08, 32'hDEAD_BEEF, "R8 direct hi");
        rd(8'h0C, 32'h1234_5678, "R8 direct lo");
        req_in = 64'hFFFF_0000_00FF_00FF;
        #1 check("R9 gated pattern", req_gated, 64'hDEAD_0000_0034_0078);
        err_in = 64'h8;
        #1 check("R10 irq masked", {63'h0, err_irq}, 64'h0);
        wr(8'h14, 32'h8);
        #1 check("R10 irq enabled", {63'h0, err_irq}, 64'h1);
        rd(8'h14, 32'h8, "R10 ee lo readback");
        err_in = 64'h1 << 40;
        #1 check("R10 other channel masked", {63'h0, err_irq}, 64'h0);
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule